// File: doc/BRIEF.md
# Page Mode Read Buffer

This block sits between a slow memory array and an asynchronous read port. When a read is requested on a page that is not yet held locally, the block asks the array for the whole page and waits a long, fixed number of system clock cycles before it captures the page into local registers. Later reads that differ only in the in-page address bits are then served from those registers after a much shorter wait. Both waits are counted in system clock cycles, and a data-valid flag marks the cycles in which the output may be used. Page reads need no burst clock.

The port is organised either as four 16-bit words per page (x16) or as two 32-bit double-words per page (x32), selected by `mode_x32`. The page held locally is dropped when the chip enable goes high or when a read moves to a different page. It is kept when only the output enable goes high. `mode_x32` is changed only while the chip enable is high.

The controller has four states. `PG_IDLE` means no read is in progress. `PG_FILL` counts the long wait. `PG_SHORT` counts the short wait. `PG_DRIVE` presents valid data. The transitions are named as follows:
- start-miss: `PG_IDLE` to `PG_FILL`, on a read whose page is not held.
- start-hit: `PG_IDLE` to `PG_SHORT`, on a read whose page is held.
- fill-retarget: `PG_FILL` to `PG_FILL`, when the page address changes; the count restarts.
- fill-done: `PG_FILL` to `PG_DRIVE`.
- offset-move: `PG_SHORT` or `PG_DRIVE` to `PG_SHORT`, when the in-page offset changes.
- short-done: `PG_SHORT` to `PG_DRIVE`.
- page-move: `PG_SHORT` or `PG_DRIVE` to `PG_FILL`, when the page address changes.
- release: any state to `PG_IDLE`, when either enable goes high.

Top module: `pgbuf_page_read`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, `data_valid` is 0 and `data_out` is all zeros.
- R2: A read of a page that is not held takes effect when `chip_en_n` and `out_en_n` are both 0 at a rising edge. `data_valid` rises after exactly FULL_LAT rising edges, counting that edge as the first.
- R3: In x16 mode, the in-page word index is address bits [2:1]. Word k is bits [16k+15:16k] of `arr_page_data`. It appears on `data_out[15:0]`, and `data_out[31:16]` is zero.
- R4: In x32 mode, address bit 2 selects double-word j, which is `arr_page_data[32j+31:32j]`. Address bit 1 is ignored: toggling it while data is valid leaves `data_valid` and `data_out` unchanged.
- R5: While a read stays active on a held page, a change of the in-page offset makes `data_valid` fall. It rises again after exactly SHORT_LAT rising edges, counting the edge that sees the change. A further change during that wait restarts the count.
- R6: While a read stays active, a change of the page address bits (bit 3 and above) costs the full FULL_LAT latency again.
- R7: A high `chip_en_n` drops the held page. The next read, even of the same page, costs FULL_LAT.
- R8: A high `out_en_n` with `chip_en_n` low keeps the held page. The next read on that page costs only SHORT_LAT and returns the correct word.
- R9: When `chip_en_n` or `out_en_n` is high at a rising edge, `data_valid` is 0 after that edge.
- R10: While data is valid and the address is stable, `arr_page_addr` equals the page address bits of `addr`.
- R11: With a held read and unchanged inputs, `data_valid` stays 1 and `data_out` stays constant.
- R12: A page address change while the long wait is still counting restarts it. Data then appears FULL_LAT edges after the change, from the new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en_n | input | 1 | Active-low chip enable; high drops the held page |
| out_en_n | input | 1 | Active-low output enable |
| mode_x32 | input | 1 | 1 selects double-word organisation, 0 selects word organisation |
| addr | input | ADDR_W-1 | Byte address bits ADDR_W-1 down to 1 |
| arr_page_addr | output | ADDR_W-3 | Page address presented to the array |
| arr_page_data | input | WORD_W*WORDS_PER_PAGE | Whole page returned by the array |
| data_out | output | 2*WORD_W | Read data, zero while not valid |
| data_valid | output | 1 | Data on `data_out` is usable |

## Verification
The bench builds the block with ADDR_W=8, FULL_LAT=5 and SHORT_LAT=2. That gives 32 pages, so every page can be opened in both organisations. Each page is reached by a page move from the previous one, and every in-page offset of it is then read at short latency. The two latencies are small and distinct, so each measured edge count tells a full fetch apart from a buffered hit. They also leave room to change the address a second time during a wait, which exercises both restart paths.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_FILL  = 2'd1,
        PG_SHORT = 2'd2,
        PG_DRIVE = 2'd3
    } pg_state_e;

endpackage

// File: rtl/pgbuf_lat_counter.sv
// Down-counter for the wait windows; `last` marks the final waiting cycle.
module pgbuf_lat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        last = (cnt_q <= CNT_W'(1));
    end

endmodule

// File: rtl/pgbuf_page_store.sv
// Local copy of one page plus the word / double-word output selector.
module pgbuf_page_store #(
    parameter int WORD_W         = 16,
    parameter int WORDS_PER_PAGE = 4,
    parameter int OFF_W          = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             capture,
    input  logic [WORD_W*WORDS_PER_PAGE-1:0] page_in,
    input  logic                             mode_x32,
    input  logic [OFF_W-1:0]                 off,
    input  logic                             valid,
    output logic [2*WORD_W-1:0]              dout
);

    logic [WORD_W-1:0] word_q [WORDS_PER_PAGE];

    for (genvar g = 0; g < WORDS_PER_PAGE; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (capture) begin
                word_q[g] <= page_in[g*WORD_W +: WORD_W];
            end
        end
    end

    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;

    always_comb begin
        lo_word = word_q[off];
        hi_word = word_q[off | OFF_W'(1)];
    end

    always_comb begin
        if (!valid) begin
            dout = '0;
        end else if (mode_x32) begin
            dout = {hi_word, lo_word};
        end else begin
            dout = {{WORD_W{1'b0}}, lo_word};
        end
    end

endmodule

// File: rtl/pgbuf_ctrl.sv
// Read controller: page tag, offset tracking, buffer validity and state.
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int PAW       = 13,
    parameter int OFF_W     = 2,
    parameter int CNT_W     = 4,
    parameter int FULL_LAT  = 8,
    parameter int SHORT_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en_n,
    input  logic             out_en_n,
    input  logic [PAW-1:0]   page_in,
    input  logic [OFF_W-1:0] off_in,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             capture,
    output logic [PAW-1:0]   tag,
    output logic [OFF_W-1:0] off,
    output logic             drive
);

    localparam logic [CNT_W-1:0] FULL_LOAD  = CNT_W'(FULL_LAT - 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_LAT - 1);

    pg_state_e        st_q, st_d;
    logic [PAW-1:0]   tag_q, tag_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic             bv_q, bv_d;
    logic             page_hit, off_hit;

    always_comb begin
        page_hit = (page_in == tag_q);
        off_hit  = (off_in == off_q);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PG_IDLE;
            tag_q <= '0;
            off_q <= '0;
            bv_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
            off_q <= off_d;
            bv_q  <= bv_d;
        end
    end

    // Next state and counter control
    always_comb begin
        st_d     = st_q;
        tag_d    = tag_q;
        off_d    = off_q;
        bv_d     = bv_q;
        cnt_load = 1'b0;
        cnt_val  = FULL_LOAD;
        cnt_dec  = 1'b0;
        capture  = 1'b0;
        if (chip_en_n) begin
            st_d = PG_IDLE;
            bv_d = 1'b0;
        end else if (out_en_n) begin
            st_d = PG_IDLE;
        end else begin
            unique case (st_q)
                PG_IDLE: begin
                    off_d    = off_in;
                    cnt_load = 1'b1;
                    if (bv_q && page_hit) begin
                        st_d    = PG_SHORT;
                        cnt_val = SHORT_LOAD;
                    end else begin
                        st_d    = PG_FILL;
                        tag_d   = page_in;
                        bv_d    = 1'b0;
                        cnt_val = FULL_LOAD;
                    end
                end
                PG_FILL: begin
                    off_d = off_in;
                    if (!page_hit) begin
                        tag_d    = page_in;
                        cnt_load = 1'b1;
                        cnt_val  = FULL_LOAD;
                    end else if (cnt_last) begin
                        st_d    = PG_DRIVE;
                        capture = 1'b1;
                        bv_d    = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                PG_SHORT: begin
                    if (!page_hit) begin
                        st_d     = PG_FILL;
                        tag_d    = page_in;
                        off_d    = off_in;
                        bv_d     = 1'b0;
                        cnt_load = 1'b1;
                        cnt_val  = FULL_LOAD;
                    end else if (!off_hit) begin
                        off_d    = off_in;
                        cnt_load = 1'b1;
                        cnt_val  = SHORT_LOAD;
                    end else if (cnt_last) begin
                        st_d = PG_DRIVE;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                PG_DRIVE: begin
                    if (!page_hit) begin
                        st_d     = PG_FILL;
                        tag_d    = page_in;
                        off_d    = off_in;
                        bv_d     = 1'b0;
                        cnt_load = 1'b1;
                        cnt_val  = FULL_LOAD;
                    end else if (!off_hit) begin
                        st_d     = PG_SHORT;
                        off_d    = off_in;
                        cnt_load = 1'b1;
                        cnt_val  = SHORT_LOAD;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        drive = (st_q == PG_DRIVE);
        tag   = tag_q;
        off   = off_q;
    end

endmodule

// File: rtl/pgbuf_page_read.sv
// Page buffer top: long fetch on a page miss, short turnaround within a page.
module pgbuf_page_read #(
    parameter int ADDR_W         = 16,
    parameter int WORD_W         = 16,
    parameter int WORDS_PER_PAGE = 4,
    parameter int FULL_LAT       = 8,
    parameter int SHORT_LAT      = 2,
    localparam int WBL           = $clog2(WORD_W / 8),
    localparam int OFF_W         = $clog2(WORDS_PER_PAGE),
    localparam int PAGE_LSB      = WBL + OFF_W,
    localparam int PAW           = ADDR_W - PAGE_LSB,
    localparam int PAGE_W        = WORD_W * WORDS_PER_PAGE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chip_en_n,
    input  logic                  out_en_n,
    input  logic                  mode_x32,
    input  logic [ADDR_W-1:WBL]   addr,
    output logic [PAW-1:0]        arr_page_addr,
    input  logic [PAGE_W-1:0]     arr_page_data,
    output logic [2*WORD_W-1:0]   data_out,
    output logic                  data_valid
);

    localparam int MAX_LAT = (FULL_LAT > SHORT_LAT) ? FULL_LAT : SHORT_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    logic [PAW-1:0]   page_in;
    logic [OFF_W-1:0] raw_off;
    logic [OFF_W-1:0] eff_off;
    logic             cnt_load, cnt_dec, cnt_last, capture, drive;
    logic [CNT_W-1:0] cnt_val;
    logic [OFF_W-1:0] off_q;

    always_comb begin
        page_in = addr[ADDR_W-1:PAGE_LSB];
        raw_off = addr[PAGE_LSB-1:WBL];
        eff_off = mode_x32 ? (raw_off & ~OFF_W'(1)) : raw_off;
    end

    pgbuf_ctrl #(
        .PAW       (PAW),
        .OFF_W     (OFF_W),
        .CNT_W     (CNT_W),
        .FULL_LAT  (FULL_LAT),
        .SHORT_LAT (SHORT_LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .page_in   (page_in),
        .off_in    (eff_off),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_dec   (cnt_dec),
        .capture   (capture),
        .tag       (arr_page_addr),
        .off       (off_q),
        .drive     (drive)
    );

    pgbuf_lat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    pgbuf_page_store #(
        .WORD_W         (WORD_W),
        .WORDS_PER_PAGE (WORDS_PER_PAGE),
        .OFF_W          (OFF_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .page_in  (arr_page_data),
        .mode_x32 (mode_x32),
        .off      (off_q),
        .valid    (drive),
        .dout     (data_out)
    );

    always_comb begin
        data_valid = drive;
    end

endmodule

// File: rtl/pgbuf_page_read_chk.sv
module pgbuf_page_read_chk #(
    parameter int ADDR_W   = 16,
    parameter int ADDR_LO  = 1,
    parameter int PAGE_LSB = 3,
    parameter int DATA_W   = 32,
    parameter int HALF_W   = 16,
    parameter int FULL_LAT = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      chip_en_n,
    input logic                      out_en_n,
    input logic                      mode_x32,
    input logic [ADDR_W-1:ADDR_LO]   addr,
    input logic [ADDR_W-PAGE_LSB-1:0] arr_page_addr,
    input logic [DATA_W-1:0]         data_out,
    input logic                      data_valid
);

    localparam int WC_W = $clog2(FULL_LAT + 2);

    logic                    active;
    logic [ADDR_W-1:ADDR_LO] addr_prev;
    logic [WC_W-1:0]         wait_cnt;

    assign active = !chip_en_n && !out_en_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_prev <= '0;
            wait_cnt  <= '0;
        end else begin
            addr_prev <= addr;
            if (active && !data_valid) begin
                if (addr != addr_prev) wait_cnt <= WC_W'(1);
                else if (wait_cnt != {WC_W{1'b1}}) wait_cnt <= wait_cnt + 1'b1;
            end else begin
                wait_cnt <= '0;
            end
        end
    end

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n || out_en_n) |=> !data_valid);

    assert_rise_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(active));

    assert_wait_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !data_valid && (addr == addr_prev)) |-> (wait_cnt < WC_W'(FULL_LAT)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && active && $stable(addr)) |=> data_valid);

    assert_steady_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid)) |-> $stable(data_out));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !mode_x32) |-> (data_out[DATA_W-1:HALF_W] == '0));

    assert_arr_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $stable(addr)) |-> (arr_page_addr == addr[ADDR_W-1:PAGE_LSB]));

endmodule

bind pgbuf_page_read pgbuf_page_read_chk #(
    .ADDR_W   (ADDR_W),
    .ADDR_LO  (WBL),
    .PAGE_LSB (PAGE_LSB),
    .DATA_W   (2 * WORD_W),
    .HALF_W   (WORD_W),
    .FULL_LAT (FULL_LAT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chip_en_n     (chip_en_n),
    .out_en_n      (out_en_n),
    .mode_x32      (mode_x32),
    .addr          (addr),
    .arr_page_addr (arr_page_addr),
    .data_out      (data_out),
    .data_valid    (data_valid)
);

// File: tb/pgbuf_page_read_tb.sv
`timescale 1ns/1ps
module pgbuf_page_read_tb;

    localparam int AW = 8;
    localparam int FL = 5;
    localparam int SL = 2;
    localparam int NPAGES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        mode_x32 = 1'b0;
    logic [7:1]  addr = '0;
    logic [4:0]  arr_page_addr;
    logic [63:0] arr_page_data;
    logic [31:0] data_out;
    logic        data_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pgbuf_page_read #(
        .ADDR_W(AW), .WORD_W(16), .WORDS_PER_PAGE(4),
        .FULL_LAT(FL), .SHORT_LAT(SL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .mode_x32(mode_x32), .addr(addr), .arr_page_addr(arr_page_addr),
        .arr_page_data(arr_page_data), .data_out(data_out), .data_valid(data_valid)
    );

    function automatic logic [15:0] pw(input int p, input int k);
        return 16'((p * 32'h0135) ^ (k * 32'h4a00) ^ 32'h0c3c);
    endfunction

    function automatic logic [31:0] expd(input bit m32, input int p, input int off);
        int j;
        if (m32) begin
            j = off / 2;
            return {pw(p, 2 * j + 1), pw(p, 2 * j)};
        end
        return {16'h0000, pw(p, off)};
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++) arr_page_data[16*k +: 16] = pw(int'(arr_page_addr), k);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit ce, input bit oe, input int p, input int off);
        chip_en_n = ce;
        out_en_n  = oe;
        addr      = {p[4:0], off[1:0]};
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!data_valid && n < 40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int off0;
        int o;
        @(negedge clk);
        step();
        step();
        chk(data_valid == 1'b0, "R1 valid in reset", data_valid, 0);
        chk(data_out == 32'h0, "R1 data in reset", data_out, 0);
        rst_n = 1'b1;
        step();
        chk(data_valid == 1'b0 && data_out == 32'h0, "R1 after reset", data_out, 0);

        for (int m = 0; m < 2; m++) begin
            mode_x32 = m[0];
            step();
            for (int p = 0; p < NPAGES; p++) begin
                off0 = p % 4;
                drive(1'b0, 1'b0, p, off0);
                wait_valid(n);
                chk(n == FL, (p == 0) ? "R2 miss latency" : "R6 page move latency", n, FL);
                chk(data_out == expd(m[0], p, off0), m[0] ? "R4 dword data" : "R3 word data",
                    data_out, expd(m[0], p, off0));
                chk(arr_page_addr == p[4:0], "R10 array page address", arr_page_addr, p);
                if (m == 0) begin
                    for (int d = 1; d < 4; d++) begin
                        o = (off0 + d) % 4;
                        drive(1'b0, 1'b0, p, o);
                        wait_valid(n);
                        chk(n == SL, "R5 in-page latency", n, SL);
                        chk(data_out == expd(1'b0, p, o), "R3 word data", data_out, expd(1'b0, p, o));
                    end
                end else begin
                    o = off0 ^ 2;
                    drive(1'b0, 1'b0, p, o);
                    wait_valid(n);
                    chk(n == SL, "R5 in-page latency x32", n, SL);
                    chk(data_out == expd(1'b1, p, o), "R4 dword data", data_out, expd(1'b1, p, o));
                    drive(1'b0, 1'b0, p, o ^ 1);
                    step();
                    chk(data_valid == 1'b1, "R4 A1 ignored valid", data_valid, 1);
                    chk(data_out == expd(1'b1, p, o), "R4 A1 ignored data", data_out, expd(1'b1, p, o));
                end
            end
            drive(1'b1, 1'b1, 0, 0);
            step();
            chk(data_valid == 1'b0, "R9 release", data_valid, 0);
        end

        mode_x32 = 1'b0;
        step();
        drive(1'b0, 1'b0, 3, 0);
        wait_valid(n);
        chk(n == FL, "R2 miss latency", n, FL);
        chip_en_n = 1'b1;
        step();
        chk(data_valid == 1'b0, "R9 chip enable high", data_valid, 0);
        drive(1'b0, 1'b0, 3, 0);
        wait_valid(n);
        chk(n == FL, "R7 refetch after chip enable", n, FL);
        out_en_n = 1'b1;
        step();
        chk(data_valid == 1'b0, "R9 output enable high", data_valid, 0);
        drive(1'b0, 1'b0, 3, 2);
        wait_valid(n);
        chk(n == SL, "R8 page kept", n, SL);
        chk(data_out == expd(1'b0, 3, 2), "R8 data", data_out, expd(1'b0, 3, 2));

        for (int h = 0; h < 4; h++) begin
            step();
            chk(data_valid == 1'b1, "R11 hold valid", data_valid, 1);
            chk(data_out == expd(1'b0, 3, 2), "R11 hold data", data_out, expd(1'b0, 3, 2));
        end

        drive(1'b0, 1'b0, 5, 1);
        step();
        step();
        chk(data_valid == 1'b0, "R12 still waiting", data_valid, 0);
        drive(1'b0, 1'b0, 9, 1);
        wait_valid(n);
        chk(n == FL, "R12 retarget latency", n, FL);
        chk(data_out == expd(1'b0, 9, 1), "R12 retarget data", data_out, expd(1'b0, 9, 1));

        drive(1'b0, 1'b0, 9, 2);
        step();
        chk(data_valid == 1'b0, "R5 offset move drops valid", data_valid, 0);
        drive(1'b0, 1'b0, 9, 3);
        wait_valid(n);
        chk(n == SL, "R5 restarted short wait", n, SL);
        chk(data_out == expd(1'b0, 9, 3), "R5 restarted data", data_out, expd(1'b0, 9, 3));

        drive(1'b1, 1'b1, 0, 0);
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule